// File: doc/BRIEF.md
# Burst-Capable Multi-Channel Serial ADC Receiver

This block is a receive-only serial master for a group of converters that share one chip-select line and one serial clock. Each converter returns its result on its own data line. The block shifts all of those lines in together, one bit per data clock, most significant bit first. When the frame closes, it presents every channel's word at once together with a one-cycle valid strobe.

A conversion burst starts in one of three ways: continuously whenever timing allows, on a hardware trigger pulse, or on a software trigger pulse. A select bit decides which of the two trigger pulses is honoured. Configuration inputs set the clock division, the chip-select-to-clock delay, the clock-to-deselect delay, the minimum deselect (acquisition) time and the number of frames per burst. A trigger that arrives during a burst is remembered and served once the burst ends. An availability input lets software park the converters in a low-power state and block all starts. A manual override drives chip-select and clock straight from two inputs, but only while the receiver is idle, so that power-down command sequences can be produced.

Top module: `adc_burst_capture`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk equals cfg_cpol, busy, raw_valid, burst_done and man_active are 0, and raw_data and sample_idx are all zero.
- R2: In each frame spi_cs_n stays low for exactly (cfg_pre_wait+1) + 2·DATA_W·(cfg_clk_div+1) + (cfg_post_wait+1) cycles. The first clock edge appears cfg_pre_wait+1 cycles after chip-select falls, and spi_sclk makes exactly 2·DATA_W transitions, one every cfg_clk_div+1 cycles.
- R3: Whenever chip-select is high and the override is inactive, spi_sclk rests at cfg_cpol. The first half period of a frame drives the opposite level.
- R4: Words are received MSB first. With cfg_cpha=0, each bit is present before the first edge of its clock period and is taken at that edge. With cfg_cpha=1, the converter moves to a bit on the first edge and the bit is taken at the second edge. Channel c lands in raw_data[c·DATA_W +: DATA_W].
- R5: raw_valid is a single-cycle strobe in the first cycle after chip-select rises at the end of a frame. raw_data changes only in that cycle and holds until the next strobe.
- R6: Between two frames of a burst, and between the back-to-back bursts of continuous operation, chip-select stays high for exactly max(cfg_sample_time,1) cycles.
- R7: One start produces cfg_samples frames (a value of 0 acts as 1). At each strobe, sample_idx holds the zero-based index of that frame within the burst. busy is high from the cycle after the start until the burst ends. burst_done pulses for one cycle once per burst.
- R8: With cfg_continuous=1 and available=1, a new burst begins straight after the last acquisition gap, with no idle cycle.
- R9: With cfg_sw_select=1 only sw_trig starts a burst. With cfg_sw_select=0 only hw_trig does. The trigger that is not selected has no effect.
- R10: Trigger pulses that arrive while a burst is running, or while the override holds the block, are collapsed into one held request. That request starts exactly one further burst as soon as the block can start.
- R11: While available=0 no burst starts. Trigger pulses and continuous mode are ignored, and a held request is dropped.
- R12: While man_req=1 and the block is idle, man_active=1, spi_cs_n follows man_cs_n and spi_sclk follows man_sclk, and no burst starts. During a burst man_req has no effect until the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_continuous | input | 1 | 1: convert continuously; 0: triggered operation |
| cfg_sw_select | input | 1 | 1: accept sw_trig; 0: accept hw_trig |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: take data on the first edge of a bit; 1: on the second |
| cfg_clk_div | input | DIV_W | System cycles per half clock period, minus one |
| cfg_pre_wait | input | DLY_W | Cycles from chip-select low to first edge, minus one |
| cfg_post_wait | input | DLY_W | Cycles from the final half period to chip-select high, minus one |
| cfg_samples | input | CNT_W | Frames per burst (0 treated as 1) |
| cfg_sample_time | input | CNT_W | Minimum chip-select high time between frames |
| hw_trig | input | 1 | Hardware trigger pulse |
| sw_trig | input | 1 | Software trigger pulse |
| available | input | 1 | 0 blocks every start (converters powered down) |
| man_req | input | 1 | Request manual pin control |
| man_cs_n | input | 1 | Manual chip-select level |
| man_sclk | input | 1 | Manual serial clock level |
| spi_miso | input | NUM_CH | Serial data, one line per converter |
| spi_cs_n | output | 1 | Shared chip-select, active low |
| spi_sclk | output | 1 | Shared serial clock |
| raw_data | output | NUM_CH·DATA_W | Received words, channel 0 in the low bits |
| raw_valid | output | 1 | One-cycle strobe: raw_data updated |
| sample_idx | output | CNT_W | Index of the current frame in the burst |
| busy | output | 1 | A burst is in progress |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| man_active | output | 1 | Manual override currently drives the pins |

## Verification
A fault in the shared phase counter or the half-period index shows up within one frame. The chip-select low time or the count of clock transitions is off, and the words arrive shifted by a bit, so every configuration of divider, delays, polarity and phase is swept and both the pin timing and the received words are compared against arithmetic expectations. A fault in the burst index or the acquisition gap shows up at the second frame of a burst, as a wrong sample_idx at the strobe or a wrong high time. A lost or duplicated held trigger, or a start that slips past the availability or override gating, shows up only as a wrong frame count several hundred cycles later, so those cases are counted over whole bursts.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_CLK  = 3'd2,
    ST_POST = 3'd3,
    ST_GAP  = 3'd4
  } frm_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_trig_arb.sv
module adc_trig_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic run_continuous,
  input  logic sel_software,
  input  logic hw_trig,
  input  logic sw_trig,
  input  logic available,
  input  logic hold_manual,
  input  logic ready,
  output logic start
);

  logic pend_q;
  logic pend_d;
  logic trig_evt;
  logic req;

  always_comb begin
    trig_evt = available & ~run_continuous & (sel_software ? sw_trig : hw_trig);
    req      = available & (run_continuous | trig_evt | pend_q);
    start    = req & ready & ~hold_manual;
  end

  always_comb begin
    pend_d = pend_q;
    if (!available)    pend_d = 1'b0;
    else if (start)    pend_d = 1'b0;
    else if (trig_evt) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_TRIG_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && !start) |=> pend_q); // R10

  AST_HELD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !available |=> !pend_q); // R11

endmodule

// File: rtl/adc_chan_shift.sv
module adc_chan_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              load,
  input  logic              miso,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_d;
  logic [DATA_W-1:0] sh_next;
  logic [DATA_W-1:0] word_q;

  generate
    if (DATA_W == 1) begin : g_single
      always_comb sh_next = miso;
    end else begin : g_multi
      always_comb sh_next = {sh_q[DATA_W-2:0], miso};
    end
  endgenerate

  always_comb sh_d = capture ? sh_next : sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= sh_q;
  end

  assign word = word_q;

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [DIV_W-1:0] cfg_clk_div,
  input  logic [DLY_W-1:0] cfg_pre_wait,
  input  logic [DLY_W-1:0] cfg_post_wait,
  input  logic [CNT_W-1:0] cfg_samples,
  input  logic [CNT_W-1:0] cfg_sample_time,
  output frm_state_e       state,
  output logic             ready,
  output logic             capture,
  output logic             frame_end,
  output logic             burst_end,
  output logic             frame_cs_n,
  output logic             frame_sclk,
  output logic [CNT_W-1:0] smp_idx
);

  localparam int CW        = max3(DIV_W, DLY_W, CNT_W);
  localparam int HALF_N    = 2 * DATA_W;
  localparam int HW        = (HALF_N > 2) ? $clog2(HALF_N) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_N - 1);

  frm_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [HW-1:0]    half_q, half_d;
  logic [CNT_W-1:0] smp_q, smp_d;

  logic          pre_hit, div_hit, post_hit, gap_end, last_smp;
  logic [CW:0]   cnt_p1;
  logic [CNT_W:0] smp_p1;

  always_comb begin
    pre_hit  = (cnt_q == CW'(cfg_pre_wait));
    div_hit  = (cnt_q == CW'(cfg_clk_div));
    post_hit = (cnt_q == CW'(cfg_post_wait));
    cnt_p1   = {1'b0, cnt_q} + (CW+1)'(1);
    gap_end  = (cnt_p1 >= (CW+1)'(cfg_sample_time));
    smp_p1   = {1'b0, smp_q} + (CNT_W+1)'(1);
    last_smp = (smp_p1 >= {1'b0, cfg_samples});
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    smp_d   = smp_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PRE;
          cnt_d   = '0;
          smp_d   = '0;
        end
      end
      ST_PRE: begin
        if (pre_hit) begin
          state_d = ST_CLK;
          cnt_d   = '0;
          half_d  = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_CLK: begin
        if (div_hit) begin
          cnt_d = '0;
          if (half_q == HALF_LAST) state_d = ST_POST;
          else                     half_d  = half_q + HW'(1);
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_POST: begin
        if (post_hit) begin
          state_d = ST_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_GAP: begin
        if (gap_end) begin
          cnt_d = '0;
          if (!last_smp) begin
            state_d = ST_PRE;
            smp_d   = smp_q + CNT_W'(1);
          end else if (start) begin
            state_d = ST_PRE;
            smp_d   = '0;
          end else begin
            state_d = ST_IDLE;
            smp_d   = '0;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      smp_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      smp_q   <= smp_d;
    end
  end

  always_comb begin
    burst_end  = (state_q == ST_GAP) && gap_end && last_smp;
    ready      = (state_q == ST_IDLE) || burst_end;
    frame_end  = (state_q == ST_POST) && post_hit;
    capture    = ((state_q == ST_PRE) && pre_hit && !cfg_cpha) ||
                 ((state_q == ST_CLK) && div_hit && (half_q != HALF_LAST) &&
                  (half_q[0] != cfg_cpha));
    frame_cs_n = !((state_q == ST_PRE) || (state_q == ST_CLK) || (state_q == ST_POST));
    frame_sclk = (state_q == ST_CLK) ? (cfg_cpol ^ ~half_q[0]) : cfg_cpol;
  end

  assign state   = state_q;
  assign smp_idx = smp_q;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> ((smp_q == '0) || ({1'b0, smp_q} < {1'b0, cfg_samples}))); // R7

  AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_PRE && state_q == ST_CLK) |-> (half_q == '0)); // R2

endmodule

// File: rtl/adc_burst_capture.sv
module adc_burst_capture
  import adc_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_continuous,
  input  logic                     cfg_sw_select,
  input  logic                     cfg_cpol,
  input  logic                     cfg_cpha,
  input  logic [DIV_W-1:0]         cfg_clk_div,
  input  logic [DLY_W-1:0]         cfg_pre_wait,
  input  logic [DLY_W-1:0]         cfg_post_wait,
  input  logic [CNT_W-1:0]         cfg_samples,
  input  logic [CNT_W-1:0]         cfg_sample_time,
  input  logic                     hw_trig,
  input  logic                     sw_trig,
  input  logic                     available,
  input  logic                     man_req,
  input  logic                     man_cs_n,
  input  logic                     man_sclk,
  input  logic [NUM_CH-1:0]        spi_miso,
  output logic                     spi_cs_n,
  output logic                     spi_sclk,
  output logic [NUM_CH*DATA_W-1:0] raw_data,
  output logic                     raw_valid,
  output logic [CNT_W-1:0]         sample_idx,
  output logic                     busy,
  output logic                     burst_done,
  output logic                     man_active
);

  logic       rst_meta_q, rst_sync_q;
  logic       start, ready, capture, frame_end, burst_end;
  logic       frame_cs_n, frame_sclk;
  logic       raw_valid_q, done_q;
  frm_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  adc_trig_arb u_arb (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .run_continuous (cfg_continuous),
    .sel_software   (cfg_sw_select),
    .hw_trig        (hw_trig),
    .sw_trig        (sw_trig),
    .available      (available),
    .hold_manual    (man_req),
    .ready          (ready),
    .start          (start)
  );

  adc_frame_fsm #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .DLY_W  (DLY_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_sync_q),
    .start           (start),
    .cfg_cpol        (cfg_cpol),
    .cfg_cpha        (cfg_cpha),
    .cfg_clk_div     (cfg_clk_div),
    .cfg_pre_wait    (cfg_pre_wait),
    .cfg_post_wait   (cfg_post_wait),
    .cfg_samples     (cfg_samples),
    .cfg_sample_time (cfg_sample_time),
    .state           (state),
    .ready           (ready),
    .capture         (capture),
    .frame_end       (frame_end),
    .burst_end       (burst_end),
    .frame_cs_n      (frame_cs_n),
    .frame_sclk      (frame_sclk),
    .smp_idx         (sample_idx)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      adc_chan_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_sync_q),
        .capture (capture),
        .load    (frame_end),
        .miso    (spi_miso[c]),
        .word    (raw_data[c*DATA_W +: DATA_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else if (!rst_sync_q) begin
      raw_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      raw_valid_q <= frame_end;
      done_q      <= burst_end;
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    man_active = man_req && (state == ST_IDLE);
    spi_cs_n   = man_active ? man_cs_n : frame_cs_n;
    spi_sclk   = man_active ? man_sclk : frame_sclk;
    raw_valid  = raw_valid_q;
    burst_done = done_q;
  end

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!man_active && spi_cs_n) |-> (spi_sclk == cfg_cpol)); // R3

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    raw_valid |=> !raw_valid); // R5

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(raw_data) |-> raw_valid); // R5

  AST_START_AVAIL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($past(state) == ST_IDLE && state == ST_PRE) |-> $past(available)); // R11

  AST_NO_START_MANUAL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (man_req && state == ST_IDLE) |=> (state == ST_IDLE)); // R12

endmodule

// File: tb/adc_burst_capture_tb.sv
module adc_burst_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_continuous, cfg_sw_select, cfg_cpol, cfg_cpha;
  logic [15:0] cfg_clk_div;
  logic [7:0]  cfg_pre_wait, cfg_post_wait;
  logic [15:0] cfg_samples, cfg_sample_time;
  logic hw_trig, sw_trig, available, man_req, man_cs_n, man_sclk;
  logic [NC-1:0] spi_miso;
  logic spi_cs_n, spi_sclk;
  logic [NC*DW-1:0] raw_data;
  logic raw_valid, busy, burst_done, man_active;
  logic [15:0] sample_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_burst_capture #(.DATA_W(DW), .NUM_CH(NC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_continuous(cfg_continuous), .cfg_sw_select(cfg_sw_select),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_clk_div(cfg_clk_div), .cfg_pre_wait(cfg_pre_wait), .cfg_post_wait(cfg_post_wait),
    .cfg_samples(cfg_samples), .cfg_sample_time(cfg_sample_time),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .available(available),
    .man_req(man_req), .man_cs_n(man_cs_n), .man_sclk(man_sclk),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .raw_data(raw_data), .raw_valid(raw_valid), .sample_idx(sample_idx),
    .busy(busy), .burst_done(burst_done), .man_active(man_active)
  );

  // converter model: counts clock transitions while selected
  logic [DW-1:0] adc_word [NC];
  int ecnt = 0;
  always @(negedge spi_cs_n) ecnt = 0;
  always @(spi_sclk) if (!spi_cs_n) ecnt = ecnt + 1;
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      int k;
      if (cfg_cpha) k = (ecnt == 0) ? DW : (ecnt - 1) / 2;
      else          k = ecnt / 2;
      spi_miso[c] = (k < DW) ? adc_word[c][DW-1-k] : 1'b0;
    end
  end

  // pin monitor, sampled at the falling clock edge
  int checks = 0, errors = 0;
  int low_cnt = 0, hi_cnt = 0, first_edge = 0, edge_cnt = 0;
  int last_low = 0, last_first = 0, last_edges = 0;
  int frames = 0, rv_cnt = 0, done_cnt = 0, sclk_idle_err = 0;
  int hi_hist [16];
  int idx_hist [16];
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n) begin
        if (prev_cs) begin
          if (frames < 16) hi_hist[frames] = hi_cnt;
          frames = frames + 1;
          low_cnt = 0; edge_cnt = 0; first_edge = 0;
        end
        low_cnt = low_cnt + 1;
        if (!prev_cs && spi_sclk != prev_sclk) begin
          edge_cnt = edge_cnt + 1;
          if (first_edge == 0) first_edge = low_cnt;
        end
      end else begin
        if (!prev_cs) begin
          last_low = low_cnt; last_edges = edge_cnt; last_first = first_edge;
          hi_cnt = 0;
        end
        hi_cnt = hi_cnt + 1;
        if (!man_active && spi_sclk != cfg_cpol) sclk_idle_err = sclk_idle_err + 1;
      end
      if (raw_valid) begin
        if (rv_cnt < 16) idx_hist[rv_cnt] = int'(sample_idx);
        rv_cnt = rv_cnt + 1;
      end
      if (burst_done) done_cnt = done_cnt + 1;
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    frames = 0; rv_cnt = 0; done_cnt = 0;
    for (int i = 0; i < 16; i++) begin hi_hist[i] = -1; idx_hist[i] = -1; end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sw();
    tick(1); sw_trig = 1'b1;
    tick(1); sw_trig = 1'b0;
  endtask

  task automatic pulse_hw();
    tick(1); hw_trig = 1'b1;
    tick(1); hw_trig = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    tick(3);
  endtask

  function automatic logic [NC*DW-1:0] exp_raw();
    logic [NC*DW-1:0] v;
    for (int c = 0; c < NC; c++) v[c*DW +: DW] = adc_word[c];
    return v;
  endfunction

  task automatic set_words(input int seed);
    for (int c = 0; c < NC; c++) adc_word[c] = DW'(seed * 37 + c * 91 + 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_continuous = 0; cfg_sw_select = 1; cfg_cpol = 1; cfg_cpha = 0;
    cfg_clk_div = 0; cfg_pre_wait = 0; cfg_post_wait = 0;
    cfg_samples = 1; cfg_sample_time = 1;
    hw_trig = 0; sw_trig = 0; available = 1; man_req = 0; man_cs_n = 1; man_sclk = 0;
    set_words(1);
    clr_mon();
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sclk == 1'b1, "R1 sclk", spi_sclk, 1);
    check(busy == 0 && raw_valid == 0 && burst_done == 0 && man_active == 0, "R1 flags",
          {busy, raw_valid, burst_done, man_active}, 0);
    check(raw_data == '0, "R1 raw_data", raw_data, 0);
    check(sample_idx == '0, "R1 sample_idx", sample_idx, 0);

    // R2 R3 R4 R5 sweep of polarity, phase, divider and delays
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int dv = 0; dv < 3; dv++)
          for (int pi = 0; pi < 2; pi++)
            for (int qi = 0; qi < 2; qi++) begin
              tick(1);
              cfg_cpol = pol[0]; cfg_cpha = pha[0];
              cfg_clk_div = 16'(dv); cfg_pre_wait = 8'(pi * 3); cfg_post_wait = 8'(qi * 2);
              set_words(pol * 24 + pha * 12 + dv * 4 + pi * 2 + qi + 3);
              tick(2);
              clr_mon();
              pulse_sw();
              wait_idle();
              check(last_low == (pi*3 + 1) + 2*DW*(dv + 1) + (qi*2 + 1), "R2 cs low cycles",
                    last_low, (pi*3 + 1) + 2*DW*(dv + 1) + (qi*2 + 1));
              check(last_first == pi*3 + 2, "R2 first edge", last_first, pi*3 + 2);
              check(last_edges == 2*DW, "R2 edge count", last_edges, 2*DW);
              check(raw_data == exp_raw(), "R4 received words", raw_data, exp_raw());
              check(rv_cnt == 1, "R5 strobe count", rv_cnt, 1);
            end
    check(sclk_idle_err == 0, "R3 idle clock level", sclk_idle_err, 0);

    // R5 raw_data holds after the strobe
    set_words(77);
    tick(20);
    check(raw_data != exp_raw() || exp_raw() == raw_data && 0, "R5 hold", 0, 0);

    // R6 R7 bursts with several acquisition times
    tick(1);
    cfg_cpol = 1; cfg_cpha = 0; cfg_clk_div = 0; cfg_pre_wait = 1; cfg_post_wait = 1;
    for (int si = 0; si < 4; si++) begin
      int st;
      int g;
      st = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 5 : 9;
      g = (st < 1) ? 1 : st;
      cfg_samples = 3; cfg_sample_time = 16'(st);
      tick(2);
      clr_mon();
      pulse_sw();
      @(negedge clk);
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      wait_idle();
      check(rv_cnt == 3, "R7 frames per burst", rv_cnt, 3);
      check(idx_hist[0] == 0 && idx_hist[1] == 1 && idx_hist[2] == 2, "R7 sample_idx",
            idx_hist[0]*100 + idx_hist[1]*10 + idx_hist[2], 12);
      check(hi_hist[1] == g, "R6 gap frame 1", hi_hist[1], g);
      check(hi_hist[2] == g, "R6 gap frame 2", hi_hist[2], g);
      check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
    end

    // R7 zero frame count behaves as one
    cfg_samples = 0; cfg_sample_time = 2;
    tick(2);
    clr_mon();
    pulse_sw();
    wait_idle();
    check(rv_cnt == 1, "R7 zero samples", rv_cnt, 1);

    // R8 continuous operation, no idle cycle between bursts
    cfg_samples = 2; cfg_sample_time = 4;
    tick(2);
    clr_mon();
    cfg_continuous = 1;
    @(negedge clk);
    while (frames < 6) @(negedge clk);
    tick(1);
    cfg_continuous = 0;
    wait_idle();
    for (int f = 1; f < 5; f++)
      check(hi_hist[f] == 4, "R8 back-to-back gap", hi_hist[f], 4);
    for (int f = 0; f < 4; f++)
      check(idx_hist[f] == f % 2, "R8 sample_idx", idx_hist[f], f % 2);

    // R9 trigger source selection
    cfg_samples = 1; cfg_sample_time = 1;
    cfg_sw_select = 0;
    tick(2);
    clr_mon();
    pulse_sw();
    tick(40);
    check(frames == 0 && busy == 0, "R9 sw ignored", frames, 0);
    pulse_hw();
    wait_idle();
    check(frames == 1, "R9 hw accepted", frames, 1);
    cfg_sw_select = 1;
    tick(2);
    clr_mon();
    pulse_hw();
    tick(40);
    check(frames == 0, "R9 hw ignored", frames, 0);

    // R10 triggers during a burst collapse into one held request
    cfg_clk_div = 2;
    tick(2);
    clr_mon();
    pulse_sw();
    tick(5);
    pulse_sw();
    pulse_sw();
    wait_idle();
    check(frames == 2, "R10 one extra burst", frames, 2);
    check(hi_hist[1] == 1, "R10 held start gap", hi_hist[1], 1);

    // R11 unavailable blocks everything
    available = 0;
    tick(2);
    clr_mon();
    pulse_sw();
    tick(20);
    cfg_continuous = 1;
    tick(60);
    check(frames == 0 && busy == 0, "R11 blocked", frames, 0);
    cfg_continuous = 0;
    available = 1;
    tick(60);
    check(frames == 0, "R11 request dropped", frames, 0);

    // R12 manual override
    man_req = 1; man_cs_n = 0; man_sclk = 1;
    @(negedge clk);
    check(man_active == 1 && spi_cs_n == 0 && spi_sclk == 1, "R12 follow a",
          {man_active, spi_cs_n, spi_sclk}, 3'b101);
    tick(1);
    man_cs_n = 1; man_sclk = 0;
    @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0, "R12 follow b", {spi_cs_n, spi_sclk}, 2'b10);
    pulse_sw();
    tick(20);
    check(busy == 0, "R12 no start while manual", busy, 0);
    tick(1);
    clr_mon();
    man_req = 0;
    wait_idle();
    check(frames == 1, "R10 held through manual", frames, 1);
    tick(2);
    clr_mon();
    pulse_sw();
    tick(3);
    man_req = 1; man_cs_n = 1;
    @(negedge clk);
    check(man_active == 0 && spi_cs_n == 0, "R12 ignored while busy",
          {man_active, spi_cs_n}, 2'b00);
    wait_idle();
    check(man_active == 1, "R12 active after burst", man_active, 1);
    man_req = 0;
    tick(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule